// File: doc/BRIEF.md
# Spin-Lock Retry Backoff Controller

This block sits beside one requester of a shared lock word and decides when that requester may issue an atomic test-and-set. After a start request it polls the lock with plain reads. While the word reads as held (1), it keeps reading and never attempts the set. When a read returns free (0), it counts down its current delay and only then raises a test-and-set request. A returned old value of 0 means the lock was won, and the block holds `acquired` high until the requester releases. On release it emits a one-cycle write of 0 to the lock. A returned old value of 1 means another requester won, and the block goes back to polling.

The delay has two sources. In static mode it is a fixed slot delay that is given per requester, so different requesters fire at different times. In dynamic mode every failed test-and-set adds a pseudo-random increment. All delays are clipped to a configured ceiling. A new dynamic acquire does not start from zero or from the ceiling. It starts from the delay that won the previous acquire, shifted right by a configurable amount. The lock memory, the interconnect and coherence are outside the block. Single-cycle-capable handshake ports stand in for them.

Top module: `spin_backoff_ctrl`

## Requirements
- R1: After synchronous active-low reset, `acquired`, `rd_req`, `tas_req` and `wr_req` are low, the block is idle, and the remembered winning delay is 0.
- R2: A test-and-set acknowledged with old value 0 drives `acquired` high from the next cycle. Old value 1 returns the block to polling, so `rd_req` is high the next cycle.
- R3: While an acknowledged read returns 1 (held), the block keeps `rd_req` high and does not raise `tas_req`.
- R4: After an acknowledged read returns 0, exactly D+1 cycles follow with neither `rd_req` nor `tas_req` high, and then `tas_req` rises. D is the current delay.
- R5: With `cfg_static` = 1, D equals min(`cfg_slot`, `cfg_max`) at the start of an acquire and does not change on a failed test-and-set.
- R6: With `cfg_static` = 0, each failed test-and-set sets D to min(D + (L[DW-1:0] & `cfg_inc_mask`), `cfg_max`). L is a 16-bit register that starts at parameter SEED and advances on every failed test-and-set (either mode) to {L[14:0], L[15]^L[13]^L[12]^L[10]}. The increment uses L before it advances.
- R7: D never exceeds `cfg_max`.
- R8: With `cfg_static` = 0, a new acquire starts with D = min(W >> `cfg_shift`, `cfg_max`). W is the delay in force when the previous acquire won, in either mode.
- R9: `rel_req` while `acquired` is high makes `wr_req` high for exactly the next cycle, drops `acquired` in that cycle, and returns the block to idle with no further requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acq_req | input | 1 | Start an acquire (sampled when idle) |
| rel_req | input | 1 | Release a held lock |
| cfg_static | input | 1 | 1: fixed slot delay, 0: growing randomized delay |
| cfg_slot | input | DW | Static slot delay for this requester |
| cfg_max | input | DW | Delay ceiling |
| cfg_inc_mask | input | DW | Mask applied to the random increment |
| cfg_shift | input | SW | Right shift applied to the last winning delay |
| rd_req | output | 1 | Plain read of the lock word requested |
| rd_ack | input | 1 | Read completed this cycle |
| rd_data | input | 1 | Lock value read (1 held, 0 free) |
| tas_req | output | 1 | Test-and-set requested |
| tas_ack | input | 1 | Test-and-set completed this cycle |
| tas_old | input | 1 | Old lock value returned by test-and-set |
| wr_req | output | 1 | One-cycle write of 0 to release the lock |
| acquired | output | 1 | Lock is held by this requester |

## Verification
The bench builds the block with DW = 8, SW = 3 and SEED = 16'hACE1. An 8-bit delay with an 8-bit mask lets one or two increments reach a small ceiling, so the clipping in R6 and R7 is reached within a few retries. The same width still allows slot values far above the ceiling. A 3-bit shift covers the range from keeping the whole last delay down to dropping it almost entirely. The bench answers reads and test-and-sets in the same cycle, so every count of delay cycles is exact.

// File: rtl/spinbo_pkg.sv
// Shared types for the spin-lock backoff controller.
// Assumes nothing beyond a standard SystemVerilog package scope.
package spinbo_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_POLL  = 3'd1,
        ST_WAIT  = 3'd2,
        ST_TAS   = 3'd3,
        ST_OWNED = 3'd4
    } spinbo_state_e;

endpackage

// File: rtl/spinbo_lfsr.sv
// 16-bit Fibonacci shift register used as the random increment source.
// Advances one step when adv is high; assumes SEED is nonzero.
module spinbo_lfsr #(
    parameter logic [15:0] SEED = 16'hACE1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        adv,
    output logic [15:0] value
);

    logic feedback;

    // Feedback taps for the maximal polynomial x^16+x^14+x^13+x^11+1
    assign feedback = value[15] ^ value[13] ^ value[12] ^ value[10];

    // State register: loads seed on reset, shifts on advance
    always_ff @(posedge clk) begin
        if (!rst_n)
            value <= SEED;
        else if (adv)
            value <= {value[14:0], feedback};
    end

    p_lfsr_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        value != 16'd0);

endmodule

// File: rtl/spinbo_delay_calc.sv
// Holds the current backoff delay and the delay of the last winning attempt.
// Loads the start delay on an acquire start, grows it on a failed set
// (dynamic mode only), and records it on a win. Assumes DW <= 16.
module spinbo_delay_calc #(
    parameter int DW = 8,
    parameter int SW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          fail,
    input  logic          win,
    input  logic          static_mode,
    input  logic [DW-1:0] slot,
    input  logic [DW-1:0] max_delay,
    input  logic [DW-1:0] inc_mask,
    input  logic [SW-1:0] shift,
    input  logic [15:0]   rnd,
    output logic [DW-1:0] cur_delay
);

    localparam int SUMW = DW + 1;

    logic [DW-1:0]   last_win;
    logic [DW-1:0]   start_val;
    logic [DW-1:0]   inc;
    logic [SUMW-1:0] grown;
    logic [DW-1:0]   grown_capped;

    // Clip a value to the configured ceiling
    function automatic logic [DW-1:0] clip(input logic [SUMW-1:0] v,
                                           input logic [DW-1:0]   lim);
        return (v > {1'b0, lim}) ? lim : v[DW-1:0];
    endfunction

    // Start value: static slot or a fraction of the last winning delay
    always_comb begin
        if (static_mode)
            start_val = clip({1'b0, slot}, max_delay);
        else
            start_val = clip({1'b0, last_win >> shift}, max_delay);
    end

    // Growth value: add masked random increment, then clip
    always_comb begin
        inc          = rnd[DW-1:0] & inc_mask;
        grown        = {1'b0, cur_delay} + {1'b0, inc};
        grown_capped = clip(grown, max_delay);
    end

    // Current delay register
    always_ff @(posedge clk) begin
        if (!rst_n)
            cur_delay <= '0;
        else if (start)
            cur_delay <= start_val;
        else if (fail && !static_mode)
            cur_delay <= grown_capped;
    end

    // Winning-delay memory used by the next acquire
    always_ff @(posedge clk) begin
        if (!rst_n)
            last_win <= '0;
        else if (win)
            last_win <= cur_delay;
    end

    p_cap_after_update_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (start || fail) |=> (cur_delay <= $past(max_delay)));

    p_static_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fail && static_mode && !start) |=> $stable(cur_delay));

endmodule

// File: rtl/spinbo_timer.sv
// Down-counter for the wait between seeing the lock free and attempting
// the set. Loads on load, decrements each cycle while run and nonzero.
module spinbo_timer #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] load_val,
    input  logic          run,
    output logic          zero
);

    logic [DW-1:0] cnt;

    assign zero = (cnt == '0);

    // Count register: load has priority over decrement
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (run && !zero)
            cnt <= cnt - 1'b1;
    end

    p_no_load_while_running_r4: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !run);

endmodule

// File: rtl/spin_backoff_ctrl.sv
// Per-requester spin-lock controller: polls the lock with plain reads,
// waits a static or growing randomized delay after seeing it free, then
// issues a test-and-set. Assumes read and set handshakes acknowledge while
// the matching request is high; acks outside a request are ignored.
module spin_backoff_ctrl
    import spinbo_pkg::*;
#(
    parameter int          DW   = 8,
    parameter int          SW   = 3,
    parameter logic [15:0] SEED = 16'hACE1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acq_req,
    input  logic          rel_req,
    input  logic          cfg_static,
    input  logic [DW-1:0] cfg_slot,
    input  logic [DW-1:0] cfg_max,
    input  logic [DW-1:0] cfg_inc_mask,
    input  logic [SW-1:0] cfg_shift,
    output logic          rd_req,
    input  logic          rd_ack,
    input  logic          rd_data,
    output logic          tas_req,
    input  logic          tas_ack,
    input  logic          tas_old,
    output logic          wr_req,
    output logic          acquired
);

    spinbo_state_e state, state_nx;

    logic          ev_start;
    logic          ev_free;
    logic          ev_fail;
    logic          ev_win;
    logic          ev_release;
    logic          tmr_zero;
    logic [15:0]   rnd;
    logic [DW-1:0] cur_delay;

    // Event decode from state and handshakes
    always_comb begin
        ev_start   = (state == ST_IDLE)  && acq_req;
        ev_free    = (state == ST_POLL)  && rd_ack && !rd_data;
        ev_fail    = (state == ST_TAS)   && tas_ack && tas_old;
        ev_win     = (state == ST_TAS)   && tas_ack && !tas_old;
        ev_release = (state == ST_OWNED) && rel_req;
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (ev_start)   state_nx = ST_POLL;
            ST_POLL:  if (ev_free)    state_nx = ST_WAIT;
            ST_WAIT:  if (tmr_zero)   state_nx = ST_TAS;
            ST_TAS: begin
                if (ev_win)           state_nx = ST_OWNED;
                else if (ev_fail)     state_nx = ST_POLL;
            end
            ST_OWNED: if (ev_release) state_nx = ST_IDLE;
            default:                  state_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    // Release write strobe, one cycle after the release request
    always_ff @(posedge clk) begin
        if (!rst_n)
            wr_req <= 1'b0;
        else
            wr_req <= ev_release;
    end

    // Request and status outputs decoded from state
    always_comb begin
        rd_req   = (state == ST_POLL);
        tas_req  = (state == ST_TAS);
        acquired = (state == ST_OWNED);
    end

    spinbo_lfsr #(.SEED(SEED)) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (ev_fail),
        .value (rnd)
    );

    spinbo_delay_calc #(.DW(DW), .SW(SW)) u_delay (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (ev_start),
        .fail        (ev_fail),
        .win         (ev_win),
        .static_mode (cfg_static),
        .slot        (cfg_slot),
        .max_delay   (cfg_max),
        .inc_mask    (cfg_inc_mask),
        .shift       (cfg_shift),
        .rnd         (rnd),
        .cur_delay   (cur_delay)
    );

    spinbo_timer #(.DW(DW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ev_free),
        .load_val (cur_delay),
        .run      (state == ST_WAIT),
        .zero     (tmr_zero)
    );

    p_busy_keeps_polling_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rd_ack && rd_data) |=> (rd_req && !tas_req));

    p_set_only_after_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tas_req) |-> $past(tmr_zero));

    p_win_acquires_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tas_req && tas_ack && !tas_old) |=> acquired);

    p_fail_repolls_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tas_req && tas_ack && tas_old) |=> rd_req);

    p_release_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (acquired && rel_req) |=> (wr_req && !acquired && !rd_req));

    p_one_request_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_req, tas_req, wr_req, acquired}));

endmodule

// File: tb/tb_spin_backoff_ctrl.sv
// Self-checking bench: a lock model answering in the same cycle, directed
// corner cases, and randomized acquires checked against a bench model.
module tb_spin_backoff_ctrl;

    localparam int          DW   = 8;
    localparam int          SW   = 3;
    localparam logic [15:0] SEED = 16'hACE1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          acq_req = 1'b0;
    logic          rel_req = 1'b0;
    logic          cfg_static = 1'b0;
    logic [DW-1:0] cfg_slot = '0;
    logic [DW-1:0] cfg_max = '0;
    logic [DW-1:0] cfg_inc_mask = '0;
    logic [SW-1:0] cfg_shift = '0;
    logic          rd_req, rd_ack, rd_data;
    logic          tas_req, tas_ack, tas_old;
    logic          wr_req, acquired;
    logic          lock_bit = 1'b1;
    logic          fail_bit = 1'b0;

    int n_tests = 0;
    int n_fail  = 0;

    logic [15:0] m_lfsr = SEED;
    int          m_last = 0;

    always #10 clk = ~clk;

    assign rd_ack  = rd_req;
    assign rd_data = lock_bit;
    assign tas_ack = tas_req;
    assign tas_old = fail_bit;

    spin_backoff_ctrl #(.DW(DW), .SW(SW), .SEED(SEED)) dut (
        .clk(clk), .rst_n(rst_n), .acq_req(acq_req), .rel_req(rel_req),
        .cfg_static(cfg_static), .cfg_slot(cfg_slot), .cfg_max(cfg_max),
        .cfg_inc_mask(cfg_inc_mask), .cfg_shift(cfg_shift),
        .rd_req(rd_req), .rd_ack(rd_ack), .rd_data(rd_data),
        .tas_req(tas_req), .tas_ack(tas_ack), .tas_old(tas_old),
        .wr_req(wr_req), .acquired(acquired)
    );

    function automatic int capv(input int v, input int lim);
        return (v > lim) ? lim : v;
    endfunction

    function automatic logic [15:0] lfsr_step(input logic [15:0] l);
        return {l[14:0], l[15] ^ l[13] ^ l[12] ^ l[10]};
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // One full acquire with nfail lost sets, then the release
    task automatic run_acquire(input bit st, input int slot, input int mx,
                               input int mask, input int sh, input int nfail);
        int  busy, fails, gap, guard, exp_d;
        bit  done, chk_retry, chk_busy, first;
        cfg_static   = st;
        cfg_slot     = slot[DW-1:0];
        cfg_max      = mx[DW-1:0];
        cfg_inc_mask = mask[DW-1:0];
        cfg_shift    = sh[SW-1:0];
        exp_d = st ? capv(slot, mx) : capv(m_last >> sh, mx);
        @(negedge clk); acq_req = 1'b1;
        @(negedge clk); acq_req = 1'b0;
        busy = $urandom_range(0, 3);
        fails = nfail; gap = 0; guard = 0;
        done = 0; chk_retry = 0; chk_busy = 0; first = 1;
        while (!done && guard < 4000) begin
            guard++;
            if (chk_retry) check(rd_req == 1'b1, "R2 retry polls", rd_req, 1);
            if (chk_busy)  check(rd_req && !tas_req, "R3 keeps polling", tas_req, 0);
            chk_retry = 0; chk_busy = 0; fail_bit = 1'b0;
            if (rd_req) begin
                if (busy > 0) begin lock_bit = 1'b1; busy--; chk_busy = 1; end
                else lock_bit = 1'b0;
                gap = 0;
            end else if (tas_req) begin
                check(gap == exp_d + 1, st ? "R4/R5 wait length" :
                      (first ? "R4/R8 wait length" : "R4/R6 wait length"), gap, exp_d + 1);
                check(gap - 1 <= mx, "R7 ceiling", gap - 1, mx);
                first = 0;
                if (fails > 0) begin
                    fail_bit = 1'b1; fails--;
                    if (!st) exp_d = capv(exp_d + (m_lfsr[DW-1:0] & mask[DW-1:0]), mx);
                    m_lfsr = lfsr_step(m_lfsr);
                    busy = $urandom_range(0, 3);
                    chk_retry = 1;
                end else begin
                    done = 1;
                    m_last = exp_d;
                end
            end else begin
                gap++;
            end
            if (!done) @(negedge clk);
        end
        check(done, "R2 acquire completes", done, 1);
        @(negedge clk);
        fail_bit = 1'b0; lock_bit = 1'b1;
        check(acquired == 1'b1, "R2 acquired after win", acquired, 1);
        rel_req = 1'b1;
        @(negedge clk); rel_req = 1'b0;
        check(wr_req && !acquired, "R9 release write", {wr_req, acquired}, 2);
        @(negedge clk);
        check(!wr_req && !rd_req && !tas_req && !acquired, "R9 back to idle",
              {wr_req, rd_req, tas_req, acquired}, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0001));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!acquired && !rd_req && !tas_req && !wr_req, "R1 reset outputs",
              {acquired, rd_req, tas_req, wr_req}, 0);
        // R8 first dynamic acquire starts from remembered delay 0
        run_acquire(1'b0, 0, 20, 8'h0F, 1, 0);
        // R5 static slot with retries keeps its delay
        run_acquire(1'b1, 5, 20, 8'hFF, 0, 2);
        // R5/R7 slot above the ceiling is clipped
        run_acquire(1'b1, 30, 10, 8'h00, 0, 1);
        // R5 zero slot: one idle cycle before the set
        run_acquire(1'b1, 0, 50, 8'h00, 0, 0);
        // R6 growth, then R8 start from a fraction of the winner
        run_acquire(1'b0, 0, 40, 8'h0F, 1, 4);
        run_acquire(1'b0, 0, 40, 8'h0F, 1, 1);
        // R6/R7 small ceiling reached by growth
        run_acquire(1'b0, 0, 6, 8'hFF, 0, 5);
        // R8 shift of zero keeps the whole last delay
        run_acquire(1'b0, 0, 6, 8'h03, 0, 0);
        for (int i = 0; i < 30; i++) begin
            run_acquire($urandom_range(0, 1), $urandom_range(0, 255),
                        $urandom_range(0, 60), $urandom_range(0, 255),
                        $urandom_range(0, 7), $urandom_range(0, 4));
        end
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule